// File: doc/BRIEF.md
# Low-Power Entry Control Register with Field Locks

This block is a 16-bit control register on a simple write/read bus. It decides whether a processor core's requests for the deep-sleep (stop) and light-sleep (wait) states reach the power controller. The stop field and the wait field each have two bits. The low bit of a field vetoes its state. The high bit locks the field against any later write until the next reset.

The same word carries three more controls. One bit chooses when the debug clock runs: always, or only while the debug test port is enabled. One write-only bit asks the reset generator for a software reset, as a one-cycle pulse. A second, read-only word records which reset came last. It keeps one flag per reset source and shows whether the watchdog vector applies.

A power-on reset (`por_n` low) clears everything at once and marks power-on as the last cause. Each later reset arrives as a one-cycle event on `ev_ext`, `ev_wdog` or `ev_sw`. Such an event clears the control word, which also drops both locks. It stores only the highest-ranking cause present in that cycle.

Top module: `lpm_ctl_reg`

## Requirements
- R1: Control-word bits 15:6 always read 0, and writing ones to them changes no readable bit or output.
- R2: `dbg_clk_en` = bit 5 OR `tap_en`. With bit 5 at 0 the debug clock follows `tap_en`. With bit 5 at 1 it stays high.
- R3: Bit 4 always reads 0. A write to address 0 with bit 4 set raises `sw_rst_req` for exactly one cycle, starting at the clock edge that accepts the write.
- R4: The stop field is bits 3:2. `stop_go` = `stop_req` AND NOT bit 2. This is combinational and holds from the cycle after the write.
- R5: After a write with bit 3 set, bits 3:2 keep their value through all writes until the next reset.
- R6: The wait field is bits 1:0. `wait_go` = `wait_req` AND NOT bit 0. After a write with bit 1 set, bits 1:0 are frozen until reset.
- R7: The control word reads 0x0000 after a power-on reset. It also reads 0x0000 after any reset event, which clears both locks.
- R8: A write that meets a locked field still updates every unlocked field in the same word.
- R9: Address 1 reads the status word. Bit 0 = power-on, bit 1 = external, bit 2 = watchdog, bit 3 = software, and bits 15:4 read 0. Exactly one flag is set: the highest-ranking cause (power-on > external > watchdog > software). After power-on the word reads 0x0001. Writes to address 1 are ignored.
- R10: `wdog_vec` is high exactly when the last reset was a watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ev_ext | input | 1 | External reset event, one cycle |
| ev_wdog | input | 1 | Watchdog reset event, one cycle |
| ev_sw | input | 1 | Software reset event, one cycle |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | Word select: 0 control, 1 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| stop_req | input | 1 | Core asks for the stop state |
| wait_req | input | 1 | Core asks for the wait state |
| tap_en | input | 1 | Debug test port enabled |
| stop_go | output | 1 | Enter the stop state |
| wait_go | output | 1 | Enter the wait state |
| dbg_clk_en | output | 1 | Debug clock enable |
| sw_rst_req | output | 1 | Software reset request pulse |
| wdog_vec | output | 1 | Watchdog reset vector applies |

## Verification
The bench writes ones to a locked field together with a change to an unlocked field. A design that locked the whole word, or ignored the lock, would then read back the wrong word. It fires two reset events in the same cycle. A design with the wrong ranking, or one that ORs the flags, would show two bits or the wrong bit in the status word. It checks that a reset event drops both locks: a lock that survived a reset would keep vetoing stop or wait. It checks the software-reset pulse for one cycle only and reads bit 4 back as zero: a stored bit would stay high and keep the device in reset.

// File: rtl/lpm_ctl_reg.sv
module lpm_ctl_reg (
  input  logic        clk,
  input  logic        por_n,
  input  logic        ev_ext,
  input  logic        ev_wdog,
  input  logic        ev_sw,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        stop_req,
  input  logic        wait_req,
  input  logic        tap_en,
  output logic        stop_go,
  output logic        wait_go,
  output logic        dbg_clk_en,
  output logic        sw_rst_req,
  output logic        wdog_vec
);

  logic [1:0] stop_f, wait_f;
  logic       dbg_on;
  logic [3:0] cause;
  logic       any_ev, ctl_wr;
  logic       unused_bits;

  assign any_ev      = ev_ext | ev_wdog | ev_sw;
  assign ctl_wr      = wr_en & ~addr;
  assign unused_bits = ^wdata[15:6];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stop_f     <= 2'b00;
      wait_f     <= 2'b00;
      dbg_on     <= 1'b0;
      sw_rst_req <= 1'b0;
    end else if (any_ev) begin
      stop_f     <= 2'b00;
      wait_f     <= 2'b00;
      dbg_on     <= 1'b0;
      sw_rst_req <= 1'b0;
    end else begin
      sw_rst_req <= ctl_wr & wdata[4];
      if (ctl_wr) begin
        dbg_on <= wdata[5];
        if (!stop_f[1]) stop_f <= wdata[3:2];
        if (!wait_f[1]) wait_f <= wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cause <= 4'b0001;
    else if (ev_ext)   cause <= 4'b0010;
    else if (ev_wdog)  cause <= 4'b0100;
    else if (ev_sw)    cause <= 4'b1000;
  end

  assign rdata      = addr ? {12'h000, cause}
                           : {10'h000, dbg_on, 1'b0, stop_f, wait_f};
  assign stop_go    = stop_req & ~stop_f[0];
  assign wait_go    = wait_req & ~wait_f[0];
  assign dbg_clk_en = dbg_on | tap_en;
  assign wdog_vec   = cause[2];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !addr |-> (rdata[15:6] == 10'h000 && !rdata[4])); // R1
  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    addr |-> rdata[15:4] == 12'h000); // R9
  AST_SWRST_SRC: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst_req |-> $past(wr_en && !addr && wdata[4])); // R3
  AST_STOP_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (stop_f[1] && !any_ev) |=> $stable(stop_f)); // R5
  AST_WAIT_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (wait_f[1] && !any_ev) |=> $stable(wait_f)); // R6
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    any_ev |=> (stop_f == 2'b00 && wait_f == 2'b00 && !dbg_on)); // R7
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause) == 1); // R9

endmodule

// File: tb/tb_lpm_ctl_reg.sv
`timescale 1ns/100ps
module tb_lpm_ctl_reg;
  logic clk = 0, por_n = 0;
  logic ev_ext = 0, ev_wdog = 0, ev_sw = 0;
  logic wr_en = 0, addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic stop_req = 0, wait_req = 0, tap_en = 0;
  logic stop_go, wait_go, dbg_clk_en, sw_rst_req, wdog_vec;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  lpm_ctl_reg dut (.clk(clk), .por_n(por_n), .ev_ext(ev_ext), .ev_wdog(ev_wdog),
    .ev_sw(ev_sw), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .stop_req(stop_req), .wait_req(wait_req), .tap_en(tap_en), .stop_go(stop_go),
    .wait_go(wait_go), .dbg_clk_en(dbg_clk_en), .sw_rst_req(sw_rst_req),
    .wdog_vec(wdog_vec));

  function automatic logic [15:0] observe(int k);
    case (k)
      0: return rdata;
      1: return {15'h0, stop_go};
      2: return {15'h0, wait_go};
      3: return {15'h0, dbg_clk_en};
      4: return {15'h0, sw_rst_req};
      default: return {15'h0, wdog_vec};
    endcase
  endfunction

  initial begin : monitor
    item_t it;
    logic [15:0] act;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      act = observe(it.kind);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d act=%h exp=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_val(int k, logic [15:0] e, string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
    #0.5;
  endtask

  task automatic rd(logic a, logic [15:0] e, string tag);
    addr = a;
    #0.2;
    expect_val(0, e, tag);
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic pulse(logic e, logic w, logic s);
    @(negedge clk);
    ev_ext = e; ev_wdog = w; ev_sw = s;
    @(negedge clk);
    ev_ext = 0; ev_wdog = 0; ev_sw = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    rd(0, 16'h0000, "R7 por ctl");
    rd(1, 16'h0001, "R9 por status");
    expect_val(4, 0, "R3 idle");
    expect_val(5, 0, "R10 por vec");

    wr(0, 16'hFFC0);
    rd(0, 16'h0000, "R1 reserved");
    expect_val(4, 0, "R1 no swrst");

    expect_val(3, 0, "R2 tap0");
    tap_en = 1; #0.2;
    expect_val(3, 1, "R2 tap1");
    tap_en = 0;
    wr(0, 16'h0020);
    expect_val(3, 1, "R2 always");

    wr(0, 16'h0030);
    expect_val(4, 1, "R3 pulse");
    rd(0, 16'h0020, "R3 reads0");
    @(negedge clk);
    expect_val(4, 0, "R3 one cycle");

    stop_req = 1; wait_req = 1; #0.2;
    expect_val(1, 1, "R4 open");
    wr(0, 16'h0004);
    expect_val(1, 0, "R4 block");
    expect_val(2, 1, "R6 open");
    wr(0, 16'h0001);
    expect_val(1, 1, "R4 reopen");
    expect_val(2, 0, "R6 block");

    wr(0, 16'h000C);
    rd(0, 16'h000C, "R5 set");
    wr(0, 16'h0000);
    rd(0, 16'h000C, "R5 held");
    expect_val(1, 0, "R5 still blocked");
    wr(0, 16'h0023);
    rd(0, 16'h002F, "R8 partial");
    wr(0, 16'h0000);
    rd(0, 16'h000F, "R6 held R8");
    expect_val(2, 0, "R6 wait blocked");

    wr(1, 16'hFFFF);
    rd(1, 16'h0001, "R9 ro");

    pulse(1, 0, 1);
    rd(0, 16'h0000, "R7 evt clear");
    expect_val(1, 1, "R7 stop unlocked");
    rd(1, 16'h0002, "R9 ext wins");
    expect_val(5, 0, "R10 ext");

    wr(0, 16'h0004);
    pulse(0, 1, 1);
    rd(1, 16'h0004, "R9 wdog wins");
    expect_val(5, 1, "R10 wdog");
    rd(0, 16'h0000, "R7 wdog clear");

    pulse(0, 0, 1);
    rd(1, 16'h0008, "R9 sw");
    expect_val(5, 0, "R10 sw");

    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule